// File: doc/BRIEF.md
# Indexed configuration port controller

This block is the configuration front end of a multi-function peripheral controller. The host sees two byte-wide addresses. Offset 0 is an index port and offset 1 is a data port. After reset the block is locked. The host opens it by writing the unlock key 0x87 to the index port on two index writes in a row. Once open, the host writes a register number to the index port. Accesses to the data port then reach that register. Writing 0xAA to the index port locks the block again.

The register space has three parts:
- A logical-device number register, which selects one bank of per-device registers. The bank registers start at index 0x30.
- A fixed chip identifier.
- The bank registers themselves. Every bank register drives an output to its logical device. Bit 0 of the first bank register is the device's activate bit.

The host bus is a plain synchronous strobe interface:
- `bus_sel` picks the port.
- `bus_wr` commits `bus_wdata` at the clock edge.
- `bus_rd` presents the addressed value on `bus_rdata` in the same cycle, with no added latency.

Top module: `cfg_port_ctrl`

## Requirements
- R1: After a synchronous reset the block is locked, the logical-device number is 0, every bank register is 0x00 and every `dev_active` bit is 0.
- R2: The block opens only on the clock edge of the second of two consecutive index-port writes of 0x87. While it is not open, data-port writes change nothing, and reads of either port return 0xFF.
- R3: During the unlock sequence, an index-port write of any byte other than 0x87 returns the sequence to its start. The sequence 0x87, other, 0x87 leaves the block locked.
- R4: While open, an index-port write of 0xAA locks the block from the next cycle and does not change the index. Any other index-port write stores the byte as the current index.
- R5: While open, a data-port access targets the register named by the last stored index. A read of the index port returns that index. `bus_rdata` is 0x00 whenever `bus_rd` is low.
- R6: Index 0x07 is the logical-device number register. It is 8 bits wide and can be both written and read.
- R7: Index 0x20 reads as the parameter CHIP_ID and ignores writes.
- R8: Indices 0x30 to 0x30+BANK_REGS-1 reach register (index-0x30) of the bank of the selected device. Register k of device d drives `dev_regs[(d*BANK_REGS+k)*8 +: 8]`. Banks of other devices are unaffected.
- R9: `dev_active[d]` equals bit 0 of register 0 (index 0x30) of device d's bank.
- R10: These data-port accesses have no effect on writes and read as 0x00:
  - bank accesses while the device number is NUM_DEV or above;
  - accesses to any index other than 0x07, 0x20 and the bank range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Port select: 0 index port, 1 data port |
| bus_wr | input | 1 | Write strobe, committed at the clock edge |
| bus_rd | input | 1 | Read strobe, data returned in the same cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| dev_active | output | NUM_DEV | Activate bit of each logical device |
| dev_regs | output | NUM_DEV*BANK_REGS*8 | Bank register contents of all devices |

## Verification
The bench builds the block with NUM_DEV=3, BANK_REGS=3 and CHIP_ID=0x3C. With only three devices, device numbers 3 to 255 are easy to select, so the out-of-range case is exercised. With three bank registers, the top index 0x32 and the first unused index 0x33 are both boundary cases. The chosen identifier is not 0x00 or 0xFF, so a read of it cannot be mistaken for a locked or empty read. Beside the directed sequences, a biased random stream of unlock keys, lock bytes and indices runs against a behavioural model. Bank outputs and read data are compared with that model on every clock.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    localparam logic [7:0] KEY_UNLOCK    = 8'h87;
    localparam logic [7:0] KEY_LOCK      = 8'hAA;
    localparam logic [7:0] IDX_LDN       = 8'h07;
    localparam logic [7:0] IDX_CHIPID    = 8'h20;
    localparam logic [7:0] IDX_BANK_BASE = 8'h30;
    localparam logic [7:0] RD_LOCKED     = 8'hFF;
    localparam logic [7:0] RD_EMPTY      = 8'h00;

    typedef enum logic [1:0] {
        LK_CLOSED = 2'd0,
        LK_HALF   = 2'd1,
        LK_OPEN   = 2'd2
    } lock_state_e;

    typedef struct packed {
        logic       to_index;
        logic       to_data;
        logic [7:0] data;
    } cfg_wr_t;

    function automatic logic in_bank(input logic [7:0] idx, input int unsigned nregs);
        logic [8:0] off;
        off = {1'b0, idx} - {1'b0, IDX_BANK_BASE};
        return !off[8] && (32'(off) < nregs);
    endfunction

endpackage

// File: rtl/cfg_index_ctrl.sv
module cfg_index_ctrl
    import cfg_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       unlocked,
    output logic [7:0] index_q
);

    lock_state_e st_q, st_d;
    logic [7:0]  idx_d;

    always_comb begin
        st_d  = st_q;
        idx_d = index_q;
        if (idx_wr) begin
            case (st_q)
                LK_CLOSED: st_d = (wdata == KEY_UNLOCK) ? LK_HALF : LK_CLOSED;
                LK_HALF:   st_d = (wdata == KEY_UNLOCK) ? LK_OPEN : LK_CLOSED;
                LK_OPEN: begin
                    if (wdata == KEY_LOCK) st_d = LK_CLOSED;
                    else                   idx_d = wdata;
                end
                default:   st_d = LK_CLOSED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= LK_CLOSED;
            index_q <= '0;
        end else begin
            st_q    <= st_d;
            index_q <= idx_d;
        end
    end

    assign unlocked = (st_q == LK_OPEN);

    AST_OPEN_AFTER_PAIR: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> ($past(idx_wr) && $past(wdata) == KEY_UNLOCK && $past(st_q) == LK_HALF)); // R2

    AST_RESTART_SEQ: assert property (@(posedge clk) disable iff (rst)
        (st_q == LK_HALF && idx_wr && wdata != KEY_UNLOCK) |=> (st_q == LK_CLOSED)); // R3

    AST_RELOCK: assert property (@(posedge clk) disable iff (rst)
        (unlocked && idx_wr && wdata == KEY_LOCK) |=> (!unlocked && $stable(index_q))); // R4

endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank #(
    parameter int unsigned NREGS = 4,
    parameter int unsigned RW    = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [RW-1:0]         reg_sel,
    input  logic [7:0]            wdata,
    output logic [NREGS-1:0][7:0] regs_q,
    output logic                  active
);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else if (wr_en) begin
            for (int k = 0; k < NREGS; k++) begin
                if (reg_sel == RW'(k)) regs_q[k] <= wdata;
            end
        end
    end

    assign active = regs_q[0][0];

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs_q)); // R8

endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
    import cfg_port_pkg::*;
#(
    parameter int unsigned NUM_DEV   = 4,
    parameter int unsigned BANK_REGS = 4,
    parameter logic [7:0]  CHIP_ID   = 8'h5C
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         bus_sel,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [7:0]                   bus_wdata,
    output logic [7:0]                   bus_rdata,
    output logic [NUM_DEV-1:0]           dev_active,
    output logic [NUM_DEV*BANK_REGS*8-1:0] dev_regs
);

    localparam int unsigned RW = (BANK_REGS > 1) ? $clog2(BANK_REGS) : 1;

    cfg_wr_t                   wreq;
    logic                      unlocked;
    logic [7:0]                index_q;
    logic [7:0]                ldn_q;
    logic                      hit_bank;
    logic [RW-1:0]             reg_sel;
    logic [7:0]                rd_val;
    logic [NUM_DEV-1:0]        bank_wr;
    logic [BANK_REGS-1:0][7:0] bank_q [NUM_DEV];

    assign wreq.to_index = bus_wr && !bus_sel;
    assign wreq.to_data  = bus_wr && bus_sel && unlocked;
    assign wreq.data     = bus_wdata;

    cfg_index_ctrl u_index (
        .clk      (clk),
        .rst      (rst),
        .idx_wr   (wreq.to_index),
        .wdata    (wreq.data),
        .unlocked (unlocked),
        .index_q  (index_q)
    );

    assign hit_bank = in_bank(index_q, BANK_REGS);
    assign reg_sel  = RW'(index_q - IDX_BANK_BASE);

    always_ff @(posedge clk) begin
        if (rst)                                  ldn_q <= '0;
        else if (wreq.to_data && index_q == IDX_LDN) ldn_q <= wreq.data;
    end

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        assign bank_wr[d] = wreq.to_data && hit_bank && (ldn_q == 8'(d));

        cfg_dev_bank #(
            .NREGS (BANK_REGS),
            .RW    (RW)
        ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (bank_wr[d]),
            .reg_sel (reg_sel),
            .wdata   (wreq.data),
            .regs_q  (bank_q[d]),
            .active  (dev_active[d])
        );

        assign dev_regs[d*BANK_REGS*8 +: BANK_REGS*8] = bank_q[d];
    end

    always_comb begin
        rd_val = RD_EMPTY;
        if (!unlocked) begin
            rd_val = RD_LOCKED;
        end else if (!bus_sel) begin
            rd_val = index_q;
        end else if (index_q == IDX_LDN) begin
            rd_val = ldn_q;
        end else if (index_q == IDX_CHIPID) begin
            rd_val = CHIP_ID;
        end else if (hit_bank) begin
            for (int d = 0; d < NUM_DEV; d++) begin
                for (int k = 0; k < BANK_REGS; k++) begin
                    if (ldn_q == 8'(d) && reg_sel == RW'(k)) rd_val = bank_q[d][k];
                end
            end
        end
    end

    assign bus_rdata = bus_rd ? rd_val : RD_EMPTY;

    AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !unlocked |=> ($stable(ldn_q) && $stable(dev_regs))); // R2

    AST_LDN_RANGE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_sel && 32'(ldn_q) >= NUM_DEV) |=> $stable(dev_regs)); // R10

endmodule

// File: tb/cfg_port_ctrl_tb.sv
module cfg_port_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ND  = 3;
    localparam int NR  = 3;
    localparam logic [7:0] CID = 8'h3C;
    localparam int RW_W = ND*NR*8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [ND-1:0] dev_active;
    logic [RW_W-1:0] dev_regs;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_port_ctrl #(.NUM_DEV(ND), .BANK_REGS(NR), .CHIP_ID(CID)) u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dev_active(dev_active), .dev_regs(dev_regs)
    );

    int total = 0;
    int fails = 0;
    bit done  = 0;
    string cur_req = "R1";
    logic [7:0] last_rd;

    // behavioural reference: 0 locked, 1 one key seen, 2 open
    int m_state;
    int m_index;
    int m_ldn;
    int m_bank [ND][NR];

    task automatic chk(input logic [RW_W-1:0] act, input logic [RW_W-1:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_state = 0; m_index = 0; m_ldn = 0;
        for (int d = 0; d < ND; d++) for (int k = 0; k < NR; k++) m_bank[d][k] = 0;
    endtask

    function automatic logic [7:0] model_rd(input bit s);
        if (m_state != 2) return 8'hFF;
        if (!s) return 8'(m_index);
        if (m_index == 8'h07) return 8'(m_ldn);
        if (m_index == 8'h20) return CID;
        if (m_index >= 8'h30 && m_index < 8'h30 + NR && m_ldn < ND)
            return 8'(m_bank[m_ldn][m_index - 8'h30]);
        return 8'h00;
    endfunction

    function automatic logic [RW_W-1:0] model_regs();
        logic [RW_W-1:0] v = '0;
        for (int d = 0; d < ND; d++) for (int k = 0; k < NR; k++)
            v[(d*NR+k)*8 +: 8] = 8'(m_bank[d][k]);
        return v;
    endfunction

    function automatic logic [ND-1:0] model_act();
        logic [ND-1:0] v = '0;
        for (int d = 0; d < ND; d++) v[d] = m_bank[d][0][0];
        return v;
    endfunction

    task automatic model_step(input bit s, input bit w, input logic [7:0] d);
        if (!w) return;
        if (!s) begin
            case (m_state)
                0: m_state = (d == 8'h87) ? 1 : 0;
                1: m_state = (d == 8'h87) ? 2 : 0;
                default: if (d == 8'hAA) m_state = 0; else m_index = d;
            endcase
        end else if (m_state == 2) begin
            if (m_index == 8'h07) m_ldn = d;
            else if (m_index >= 8'h30 && m_index < 8'h30 + NR && m_ldn < ND)
                m_bank[m_ldn][m_index - 8'h30] = d;
        end
    endtask

    // one bus cycle, compared with the model on every clock
    task automatic op(input bit s, input bit w, input bit r, input logic [7:0] d);
        @(negedge clk);
        bus_sel = s; bus_wr = w; bus_rd = r; bus_wdata = d;
        #1;
        last_rd = bus_rdata;
        if (r) chk(RW_W'(bus_rdata), RW_W'(model_rd(s)), {cur_req, " read data"});
        else   chk(RW_W'(bus_rdata), RW_W'(8'h00), "R5 idle read data");
        @(posedge clk); #1;
        model_step(s, w, d);
        chk(RW_W'(dev_active), RW_W'(model_act()), {cur_req, " R9 dev_active"});
        chk(dev_regs, model_regs(), {cur_req, " R8 dev_regs"});
    endtask

    task automatic wi(input logic [7:0] d); op(1'b0, 1'b1, 1'b0, d); endtask
    task automatic wd(input logic [7:0] d); op(1'b1, 1'b1, 1'b0, d); endtask
    task automatic rdd(); op(1'b1, 1'b0, 1'b1, 8'h00); endtask
    task automatic rdi(); op(1'b0, 1'b0, 1'b1, 8'h00); endtask

    initial begin
        #(CLK_PERIOD*100000);
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog: got hung expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        model_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state
        cur_req = "R1";
        chk(RW_W'(dev_active), RW_W'(3'b000), "R1 dev_active after reset");
        chk(dev_regs, '0, "R1 dev_regs after reset");
        rdd(); chk(RW_W'(last_rd), RW_W'(8'hFF), "R1 locked data read");

        // R2: single key is not enough, writes ignored
        cur_req = "R2";
        wi(8'h87);
        wd(8'h07);
        rdd(); chk(RW_W'(last_rd), RW_W'(8'hFF), "R2 read after one key");
        rdi(); chk(RW_W'(last_rd), RW_W'(8'hFF), "R2 index read while locked");
        wi(8'h87);
        rdi(); chk(RW_W'(last_rd), RW_W'(8'h00), "R5 index read after unlock");

        // R7: chip id
        cur_req = "R7";
        wi(8'h20);
        rdd(); chk(RW_W'(last_rd), RW_W'(CID), "R7 chip id");
        wd(8'h55);
        rdd(); chk(RW_W'(last_rd), RW_W'(CID), "R7 chip id after write");

        // R6: device number
        cur_req = "R6";
        wi(8'h07); wd(8'h02);
        rdd(); chk(RW_W'(last_rd), RW_W'(8'h02), "R6 ldn readback");

        // R8/R9: banks and activate bits
        cur_req = "R8";
        wi(8'h30); wd(8'h01);
        chk(RW_W'(dev_active), RW_W'(3'b100), "R9 device 2 active");
        wi(8'h32); wd(8'hC3);
        rdd(); chk(RW_W'(last_rd), RW_W'(8'hC3), "R8 top bank register");
        wi(8'h07); wd(8'h00);
        wi(8'h31); wd(8'h5A);
        wi(8'h30); wd(8'h81);
        wi(8'h07); wd(8'h01);
        wi(8'h30); wd(8'hFE);
        cur_req = "R9";
        chk(RW_W'(dev_active), RW_W'(3'b101), "R9 bit0 only sets active");
        wi(8'h31);
        rdd(); chk(RW_W'(last_rd), RW_W'(8'h00), "R8 device 1 untouched by device 0");

        // R10: out-of-range device and unused index
        cur_req = "R10";
        wi(8'h07); wd(8'h05);
        wi(8'h30); wd(8'hFF);
        chk(RW_W'(dev_active), RW_W'(3'b101), "R10 out-of-range write ignored");
        rdd(); chk(RW_W'(last_rd), RW_W'(8'h00), "R10 out-of-range read");
        wi(8'h07); wd(8'h02);
        wi(8'h33); wd(8'h77);
        rdd(); chk(RW_W'(last_rd), RW_W'(8'h00), "R10 unused index 0x33");
        wi(8'h10);
        rdd(); chk(RW_W'(last_rd), RW_W'(8'h00), "R10 unused index 0x10");

        // R4: relock
        cur_req = "R4";
        wi(8'h07);
        wi(8'hAA);
        rdd(); chk(RW_W'(last_rd), RW_W'(8'hFF), "R4 read after lock");
        wd(8'h09);
        wi(8'h87); wi(8'h87);
        rdi(); chk(RW_W'(last_rd), RW_W'(8'h07), "R4 index kept across lock");
        rdd(); chk(RW_W'(last_rd), RW_W'(8'h02), "R4 locked write ignored");
        wi(8'hAA);

        // R3: broken sequence restarts
        cur_req = "R3";
        wi(8'h87); wi(8'h12); wi(8'h87);
        rdd(); chk(RW_W'(last_rd), RW_W'(8'hFF), "R3 interrupted key stays locked");
        wi(8'h87);
        rdi(); chk(RW_W'(last_rd), RW_W'(8'h07), "R3 fresh pair opens");

        // mixed stream against the model (R5 R8)
        cur_req = "R5";
        for (int n = 0; n < 600; n++) begin
            logic [7:0] pick;
            bit s, w, r;
            case ($urandom % 12)
                0, 1: pick = 8'h87;
                2:    pick = 8'hAA;
                3:    pick = 8'h07;
                4:    pick = 8'h20;
                5:    pick = 8'h30;
                6:    pick = 8'h31;
                7:    pick = 8'h32;
                8:    pick = 8'h33;
                9:    pick = 8'(($urandom % 5));
                default: pick = 8'($urandom);
            endcase
            s = 1'($urandom);
            w = 1'($urandom);
            r = !w || 1'($urandom);
            op(s, w, r, pick);
        end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule